// File: doc/BRIEF.md
# USB Device Event Status and Interrupt Control Registers

This block holds the event status word and the interrupt control word of a full-speed USB device controller. The protocol engine reports eight kinds of events as single-cycle pulses. Each pulse latches a sticky flag in the status word. Software reads the flags over a small register bus and clears each one by writing a zero to its bit. Writing a one to a flag leaves it as it was, so a read-modify-write cannot lose an event that arrives between the read and the write.

The control word holds one enable bit per event, in the same bit position as the event's flag. It also holds five power and reset request bits, which leave the block as plain outputs. A single interrupt line is high whenever any pending flag has its enable bit set.

On every correct-transfer event, the block also records the endpoint number and the direction of that transfer. Both fields read back in the low bits of the status word and cannot be written.

Top module: `usb_evt_irq_regs`

## Requirements
- R1: After reset the status word reads 0x0000 and the control word reads 0x0003. This means force-reset (control bit 0) and power-down (control bit 1) are high and every other control bit is low. The interrupt output is low.
- R2: A pulse on `evt_pulse[i]` sets status bit 8+i at the next clock edge and leaves the other flags unchanged. Bit 15 (i=7) is correct transfer. Bit 14 is overrun/underrun, bit 13 is error, bit 12 is wakeup, bit 11 is suspend, bit 10 is bus reset, bit 9 is start of frame and bit 8 (i=0) is expected start of frame.
- R3: A write to the status word (address 1) clears every flag whose write-data bit is 0. Every flag whose write-data bit is 1 keeps its value.
- R4: If an event pulse arrives in the same cycle as a write that clears that flag, the flag ends up set.
- R5: On each correct-transfer pulse, status bits 3:0 load `xfer_ep` and status bit 4 loads `xfer_dir`. Any other event leaves both fields unchanged.
- R6: Writes to status bits 7:0 have no effect. Status bits 7:5 always read 0.
- R7: The control word (address 0) stores written bits 15:8 (event enables) and bits 4:0. Bits 7:5 read 0. Bit 4 drives `ctl_resume`, bit 3 drives `ctl_force_suspend`, bit 2 drives `ctl_low_power`, bit 1 drives `ctl_power_down` and bit 0 drives `ctl_force_reset`.
- R8: `irq` is the OR over all events of (flag AND its enable bit). With the default configuration it follows the register state in the same cycle, so it rises in the cycle after the causing pulse or enable write.
- R9: Addresses 2 and 3 read 0, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register (combinational) |
| evt_pulse | input | 8 | Single-cycle event pulses, index i maps to status bit 8+i |
| xfer_ep | input | 4 | Endpoint number of the transfer being reported |
| xfer_dir | input | 1 | Direction of the transfer being reported |
| irq | output | 1 | Interrupt request |
| ctl_resume | output | 1 | Resume request bit |
| ctl_force_suspend | output | 1 | Force-suspend bit |
| ctl_low_power | output | 1 | Low-power mode bit |
| ctl_power_down | output | 1 | Power-down bit |
| ctl_force_reset | output | 1 | Force USB reset bit |

## Verification
The bench sweeps every one of the 256 event patterns against a changing enable pattern. It checks the flags, the interrupt line and the captured transfer fields after each pattern. A design that cleared flags on written ones, or cleared all flags on any write, fails the partial-clear and write-ones steps. The collision test sets each event while a clear-all write lands in the same cycle. A design that gives the write priority drops that event. The bench also changes the endpoint inputs during non-transfer events. It writes ones into the read-only low bits and the reserved control bits, and writes to the unused addresses. A design with a leaky decode or a field that can be written shows wrong read-back values there.

// File: rtl/usb_evt_irq_pkg.sv
package usb_evt_irq_pkg;

   // Event index into evt_pulse; status bit = EVT_LSB + index
   typedef enum logic [2:0] {
      EV_ESOF  = 3'd0,
      EV_SOF   = 3'd1,
      EV_BRST  = 3'd2,
      EV_SUSP  = 3'd3,
      EV_WAKE  = 3'd4,
      EV_ERR   = 3'd5,
      EV_OVR   = 3'd6,
      EV_XFER  = 3'd7
   } evt_idx_e;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_STAT = 2'd2
   } reg_sel_e;

   // Power/reset request positions inside the control word
   localparam int unsigned PWR_FRES = 0;
   localparam int unsigned PWR_PDWN = 1;
   localparam int unsigned PWR_LPM  = 2;
   localparam int unsigned PWR_FSUS = 3;
   localparam int unsigned PWR_RSM  = 4;
   localparam int unsigned NUM_PWR  = 5;

endpackage

// File: rtl/usb_evt_irq_addr_dec.sv
module usb_evt_irq_addr_dec
   import usb_evt_irq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned CTRL_ADDR = 0,
   parameter int unsigned STAT_ADDR = 1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   output reg_sel_e          sel_o,
   output logic              wr_ctrl_o,
   output logic              wr_stat_o
);

   if (CTRL_ADDR == STAT_ADDR) begin : g_bad_map
      $error("control and status addresses must differ");
   end
   if (CTRL_ADDR >= (1 << ADDR_W) || STAT_ADDR >= (1 << ADDR_W)) begin : g_bad_range
      $error("register address outside the address width");
   end

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

   always_comb begin
      sel_o = SEL_NONE;
      if (addr_i == CTRL_A)      sel_o = SEL_CTRL;
      else if (addr_i == STAT_A) sel_o = SEL_STAT;
   end

   assign wr_ctrl_o = we_i && (sel_o == SEL_CTRL);
   assign wr_stat_o = we_i && (sel_o == SEL_STAT);

endmodule

// File: rtl/usb_evt_irq_flag_bank.sv
module usb_evt_irq_flag_bank #(
   parameter int unsigned NUM_EVT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic               clr_wr_i,
   input  logic [NUM_EVT-1:0] clr_data_i,
   output logic [NUM_EVT-1:0] flag_o
);

   if (NUM_EVT < 1 || NUM_EVT > 16) begin : g_bad_cnt
      $error("NUM_EVT out of range");
   end

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
      logic q;
      logic kill;
      // a written zero kills the flag; a written one keeps it
      assign kill = clr_wr_i && !clr_data_i[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= evt_i[i] | (q & ~kill);
      end
      assign flag_o[i] = q;

      p_set_after_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
         evt_i[i] |=> flag_o[i]);
      p_collision_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_i[i] && clr_wr_i && !clr_data_i[i]) |=> flag_o[i]);
      p_zero_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_wr_i && !clr_data_i[i] && !evt_i[i]) |=> !flag_o[i]);
      p_one_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!evt_i[i] && !(clr_wr_i && !clr_data_i[i])) |=> $stable(flag_o[i]));
   end

endmodule

// File: rtl/usb_evt_irq_xfer_cap.sv
module usb_evt_irq_xfer_cap #(
   parameter int unsigned EP_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cap_i,
   input  logic [EP_W-1:0] ep_i,
   input  logic            dir_i,
   output logic [EP_W-1:0] ep_o,
   output logic            dir_o
);

   if (EP_W < 1 || EP_W > 8) begin : g_bad_ep
      $error("EP_W out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ep_o  <= '0;
         dir_o <= 1'b0;
      end else if (cap_i) begin
         ep_o  <= ep_i;
         dir_o <= dir_i;
      end
   end

   p_load_on_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cap_i |=> (ep_o == $past(ep_i)) && (dir_o == $past(dir_i)));
   p_hold_otherwise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_i |=> $stable(ep_o) && $stable(dir_o));

endmodule

// File: rtl/usb_evt_irq_ctrl_reg.sv
module usb_evt_irq_ctrl_reg
   import usb_evt_irq_pkg::*;
#(
   parameter int unsigned              REG_W   = 16,
   parameter int unsigned              NUM_EVT = 8,
   parameter logic [NUM_PWR-1:0]       PWR_RST = 5'b00011
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [REG_W-1:0]   wdata_i,
   output logic [NUM_EVT-1:0] mask_o,
   output logic [NUM_PWR-1:0] pwr_o
);

   localparam int unsigned EVT_LSB = REG_W - NUM_EVT;

   if (EVT_LSB < NUM_PWR) begin : g_bad_fit
      $error("event enables overlap power bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_o <= '0;
         pwr_o  <= PWR_RST;
      end else if (wr_i) begin
         mask_o <= wdata_i[REG_W-1:EVT_LSB];
         pwr_o  <= wdata_i[NUM_PWR-1:0];
      end
   end

   p_ctrl_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (mask_o == $past(wdata_i[REG_W-1:EVT_LSB])) &&
               (pwr_o == $past(wdata_i[NUM_PWR-1:0])));
   p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(mask_o) && $stable(pwr_o));

endmodule

// File: rtl/usb_evt_irq_gen.sv
module usb_evt_irq_gen #(
   parameter int unsigned NUM_EVT    = 8,
   parameter bit          IRQ_FLOP   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] flag_i,
   input  logic [NUM_EVT-1:0] mask_i,
   output logic               irq_o
);

   logic hit;
   assign hit = |(flag_i & mask_i);

   if (IRQ_FLOP) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= hit;
      end
   end else begin : g_comb
      assign irq_o = hit;
   end

   p_no_irq_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_i == '0) && $stable(mask_i) |-> !irq_o);

endmodule

// File: rtl/usb_evt_irq_regs.sv
module usb_evt_irq_regs
   import usb_evt_irq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned REG_W     = 16,
   parameter int unsigned NUM_EVT   = 8,
   parameter int unsigned EP_W      = 4,
   parameter int unsigned CTRL_ADDR = 0,
   parameter int unsigned STAT_ADDR = 1,
   parameter bit          IRQ_FLOP  = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_we,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic [NUM_EVT-1:0] evt_pulse,
   input  logic [EP_W-1:0]    xfer_ep,
   input  logic               xfer_dir,
   output logic               irq,
   output logic               ctl_resume,
   output logic               ctl_force_suspend,
   output logic               ctl_low_power,
   output logic               ctl_power_down,
   output logic               ctl_force_reset
);

   localparam int unsigned EVT_LSB  = REG_W - NUM_EVT;
   localparam int unsigned DIR_BIT  = EP_W;
   localparam int unsigned STAT_GAP = EVT_LSB - EP_W - 1;
   localparam int unsigned CTRL_GAP = EVT_LSB - NUM_PWR;
   localparam int unsigned XFER_IDX = NUM_EVT - 1;

   if (EVT_LSB < EP_W + 1) begin : g_bad_stat
      $error("status word too narrow for transfer fields");
   end

   reg_sel_e           sel;
   logic               wr_ctrl;
   logic               wr_stat;
   logic [NUM_EVT-1:0] flags;
   logic [NUM_EVT-1:0] masks;
   logic [NUM_PWR-1:0] pwr;
   logic [EP_W-1:0]    cap_ep;
   logic               cap_dir;
   logic [REG_W-1:0]   stat_word;
   logic [REG_W-1:0]   ctrl_word;

   usb_evt_irq_addr_dec #(
      .ADDR_W    (ADDR_W),
      .CTRL_ADDR (CTRL_ADDR),
      .STAT_ADDR (STAT_ADDR)
   ) u_dec (
      .addr_i    (reg_addr),
      .we_i      (reg_we),
      .sel_o     (sel),
      .wr_ctrl_o (wr_ctrl),
      .wr_stat_o (wr_stat)
   );

   usb_evt_irq_flag_bank #(
      .NUM_EVT (NUM_EVT)
   ) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_pulse),
      .clr_wr_i   (wr_stat),
      .clr_data_i (reg_wdata[REG_W-1:EVT_LSB]),
      .flag_o     (flags)
   );

   usb_evt_irq_xfer_cap #(
      .EP_W (EP_W)
   ) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .cap_i (evt_pulse[XFER_IDX]),
      .ep_i  (xfer_ep),
      .dir_i (xfer_dir),
      .ep_o  (cap_ep),
      .dir_o (cap_dir)
   );

   usb_evt_irq_ctrl_reg #(
      .REG_W   (REG_W),
      .NUM_EVT (NUM_EVT),
      .PWR_RST (5'b00011)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_ctrl),
      .wdata_i (reg_wdata),
      .mask_o  (masks),
      .pwr_o   (pwr)
   );

   usb_evt_irq_gen #(
      .NUM_EVT  (NUM_EVT),
      .IRQ_FLOP (IRQ_FLOP)
   ) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag_i (flags),
      .mask_i (masks),
      .irq_o  (irq)
   );

   assign stat_word = {flags, {STAT_GAP{1'b0}}, cap_dir, cap_ep};
   assign ctrl_word = {masks, {CTRL_GAP{1'b0}}, pwr};

   always_comb begin
      unique case (sel)
         SEL_CTRL: reg_rdata = ctrl_word;
         SEL_STAT: reg_rdata = stat_word;
         default:  reg_rdata = '0;
      endcase
   end

   assign ctl_resume        = pwr[PWR_RSM];
   assign ctl_force_suspend = pwr[PWR_FSUS];
   assign ctl_low_power     = pwr[PWR_LPM];
   assign ctl_power_down    = pwr[PWR_PDWN];
   assign ctl_force_reset   = pwr[PWR_FRES];

   p_low_fields_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !evt_pulse[XFER_IDX]) |=> $stable(stat_word[DIR_BIT:0]));
   p_unmapped_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && sel == SEL_NONE) |=> $stable(ctrl_word));

endmodule

// File: tb/usb_evt_irq_regs_tb.sv
module usb_evt_irq_regs_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [7:0]  evt_pulse = '0;
   logic [3:0]  xfer_ep = '0;
   logic        xfer_dir = 1'b0;
   logic        irq;
   logic        ctl_resume, ctl_force_suspend, ctl_low_power, ctl_power_down, ctl_force_reset;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   usb_evt_irq_regs u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
      .xfer_ep(xfer_ep), .xfer_dir(xfer_dir), .irq(irq),
      .ctl_resume(ctl_resume), .ctl_force_suspend(ctl_force_suspend),
      .ctl_low_power(ctl_low_power), .ctl_power_down(ctl_power_down),
      .ctl_force_reset(ctl_force_reset)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
      reg_addr = a;
      #2;
      d = reg_rdata;
   endtask

   task automatic pulse(input logic [7:0] e, input logic [3:0] ep, input logic dir);
      @(negedge clk);
      evt_pulse = e; xfer_ep = ep; xfer_dir = dir;
      @(negedge clk);
      evt_pulse = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] rd;
      logic [3:0]  exp_ep = '0;
      logic        exp_dir = 1'b0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_read(2'd1, rd); check("R1 status reset", rd, 16'h0000);
      bus_read(2'd0, rd); check("R1 control reset", rd, 16'h0003);
      check("R1 irq reset", {15'd0, irq}, 16'h0000);
      check("R1 outputs reset",
            {11'd0, ctl_resume, ctl_force_suspend, ctl_low_power, ctl_power_down, ctl_force_reset},
            16'h0003);

      // R7 control storage, reserved bits and outputs
      bus_write(2'd0, 16'hFFFF);
      bus_read(2'd0, rd); check("R7 control all ones", rd, 16'hFF1F);
      check("R7 outputs all ones",
            {11'd0, ctl_resume, ctl_force_suspend, ctl_low_power, ctl_power_down, ctl_force_reset},
            16'h001F);
      bus_write(2'd0, 16'h00F4);
      bus_read(2'd0, rd); check("R7 control reserved", rd, 16'h0014);
      check("R7 outputs pattern",
            {11'd0, ctl_resume, ctl_force_suspend, ctl_low_power, ctl_power_down, ctl_force_reset},
            16'h0014);

      // R9 unused addresses
      bus_write(2'd2, 16'hFFFF);
      bus_write(2'd3, 16'h0000);
      bus_read(2'd2, rd); check("R9 addr2 reads zero", rd, 16'h0000);
      bus_read(2'd3, rd); check("R9 addr3 reads zero", rd, 16'h0000);
      bus_read(2'd0, rd); check("R9 control untouched", rd, 16'h0014);

      // R2 R3 R5 R6 R8 sweep over every event pattern
      for (int p = 0; p < 256; p++) begin
         logic [7:0] m;
         logic [7:0] pv;
         pv = 8'(p);
         m  = 8'((p * 37 + 11) & 255);
         bus_write(2'd0, {m, 8'h00});
         pulse(pv, pv[3:0] ^ 4'h5, pv[4] ^ pv[0]);
         if (pv[7]) begin
            exp_ep  = pv[3:0] ^ 4'h5;
            exp_dir = pv[4] ^ pv[0];
         end
         check("R8 irq after pulse", {15'd0, irq}, {15'd0, |(pv & m)});
         bus_read(2'd1, rd);
         check("R2 R5 status after pulse", rd, {pv, 3'b000, exp_dir, exp_ep});
         bus_write(2'd1, 16'hFFFF);
         bus_read(2'd1, rd);
         check("R3 R6 ones keep", rd, {pv, 3'b000, exp_dir, exp_ep});
         bus_write(2'd1, {~(pv & 8'h0F), 8'h00});
         bus_read(2'd1, rd);
         check("R3 partial clear", rd, {pv & 8'hF0, 3'b000, exp_dir, exp_ep});
         bus_write(2'd1, 16'h00E0 ^ {8'h00, 3'b000, ~exp_dir, ~exp_ep});
         bus_read(2'd1, rd);
         check("R3 R6 clear all", rd, {8'h00, 3'b000, exp_dir, exp_ep});
         check("R8 irq cleared", {15'd0, irq}, 16'h0000);
      end

      // R4 event collides with a clearing write
      for (int i = 0; i < 8; i++) begin
         pulse(8'hFF, 4'h0, 1'b0);
         exp_ep = 4'h0; exp_dir = 1'b0;
         @(negedge clk);
         reg_addr = 2'd1; reg_wdata = 16'h0000; reg_we = 1'b1;
         evt_pulse = 8'(1 << i);
         xfer_ep = 4'hA; xfer_dir = 1'b1;
         @(negedge clk);
         reg_we = 1'b0; evt_pulse = '0;
         if (i == 7) begin exp_ep = 4'hA; exp_dir = 1'b1; end
         bus_read(2'd1, rd);
         check("R4 collision keeps flag", rd, {8'(1 << i), 3'b000, exp_dir, exp_ep});
         bus_write(2'd1, 16'h0000);
      end

      // R5 non-transfer events do not move the captured fields
      pulse(8'h80, 4'h3, 1'b1);
      pulse(8'h7F, 4'hC, 1'b0);
      bus_read(2'd1, rd);
      check("R5 capture held", rd, {8'hFF, 3'b000, 1'b1, 4'h3});

      // R8 irq follows an enable write with flags already pending
      bus_write(2'd0, 16'h0000);
      check("R8 irq masked", {15'd0, irq}, 16'h0000);
      bus_write(2'd0, 16'h0100);
      check("R8 irq on enable", {15'd0, irq}, 16'h0001);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule